// File: doc/BRIEF.md
# Infrared Carrier Modulator with One-Shot Envelope Timer

This block produces the drive signal for an infrared remote-control emitter. A carrier square wave, whose high and low phases are each set by a count register, is gated by a one-shot down timer that sets how long a burst lasts. Software sets up the block through a small register-write port. It loads the two carrier phase counts and the timer preload, and then writes a control word that starts the burst. When the timer runs out, a sticky completion flag is raised.

The timer is a 9-bit down counter. It advances once every 64 system clocks. A control bit selects whether the timer envelope reaches the output at all. A bit in the high-phase register bypasses the carrier, so the output then follows the envelope directly. When the envelope closes during a carrier high phase, that high phase still runs to its full length. Emitted pulses are never shortened.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset `ir_drive` and `tmr_done` are 0, and they stay 0 until a burst is started.
- R2: Register address 0 holds the high-phase setting. Bits 8:0 give the count H and bit 9 is the carrier-bypass bit. Address 1 holds the low-phase count L in bits 8:0. In carrier mode (bit 9 = 0) each high phase lasts H+1 clocks and each low phase lasts L+1 clocks, so a count of 0 still gives one clock.
- R3: Bit 9 of a write to address 1 has no effect, because the low-phase count is always taken as 9 bits with a zero top bit.
- R4: With the bypass bit set, `ir_drive` is high for exactly the envelope time and shows no carrier pulses.
- R5: Address 2 holds the 9-bit timer preload N. The timer starts only when address 3 is written with bit 0 = 1. The envelope then opens on the next cycle and lasts 64·N clocks for N ≥ 1. A control write with bit 0 = 0 starts nothing.
- R6: When the count reaches zero the timer stops and `tmr_done` rises, 64·N clocks after the start write.
- R7: A start write made while the timer is running reloads the preload and restarts the prescaler, and the full new envelope is timed from that write.
- R8: Control bit 2 works as a keep bit for the flag. A control write with bit 2 = 0 clears `tmr_done`, and a write with bit 2 = 1 leaves it set.
- R9: Control bit 1 routes the envelope to the output. When it is 0 a burst keeps `ir_drive` at 0 but still sets `tmr_done`.
- R10: In carrier mode the first high phase begins one clock after the envelope opens. A new high phase begins only while the envelope is open. A high phase that has started always completes its H+1 clocks, even after the envelope closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 high phase, 1 low phase, 2 preload, 3 control |
| wr_data | input | 10 | Write data |
| tmr_done | output | 1 | Sticky end-of-timer flag |
| ir_drive | output | 1 | Emitter drive enable, 1 = drive |

## Verification
The key corner case is a burst whose envelope closes in the middle of a high phase. A design that chopped that pulse would give a last pulse narrower than H+1, or end the output at the envelope boundary. A second group of tests targets zero phase counts and the ignored top bit of the low-phase register. A design that got these wrong would stretch phases or leave them empty. A third group targets a restart during a running burst and the keep bit of the flag. A wrong design would raise the flag from the old count too early, or clear the flag when told to keep it. Pulse counts, widths, gaps and the flag time are all compared with values worked out from H, L and N.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;
  localparam logic [1:0] ADDR_HIGH = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_PRE  = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_ROUTE = 1;
  localparam int CTRL_KEEP  = 2;

  typedef enum logic [1:0] {
    CG_IDLE = 2'd0,
    CG_HIGH = 2'd1,
    CG_LOW  = 2'd2
  } cg_state_e;
endpackage

// File: rtl/ir_prescaler.sv
module ir_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = en && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en)
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: a tick is only ever followed by a prescaler restart from zero
  p_tick_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/ir_down_timer.sv
module ir_down_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] preload,
  input  logic         tick,
  input  logic         flag_clr,
  output logic         running,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         done_q, done_d;
  logic         expire;

  assign expire = run_q && tick && !start && (cnt_q <= W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = done_q;
    if (flag_clr)
      done_d = 1'b0;
    if (start) begin
      cnt_d = preload;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      if (cnt_q <= W'(1)) begin
        cnt_d  = '0;
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign running = run_q;
  assign done    = done_q;

  // R5: each tick lowers a count above one by exactly one
  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !start && cnt_q > W'(1)) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));
  // R5: an idle timer holds its count until started
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> ($stable(cnt_q) && !run_q));
  // R6: expiry stops the timer and raises the flag
  p_stop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!run_q && done_q));
  // R8: a clearing write with no expiry leaves the flag low
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !expire) |=> !done_q);
  // R7: a start always reloads the count and runs
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == $past(preload)));
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         env,
  input  logic         car_en,
  input  logic [W-1:0] hi_lim,
  input  logic [W-1:0] lo_lim,
  output logic         pulse_hi
);
  import ir_carrier_pkg::*;

  cg_state_e    st_q, st_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         hi_end, lo_end;

  assign hi_end = (cnt_q >= hi_lim);
  assign lo_end = (cnt_q >= lo_lim);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!car_en) begin
      st_d  = CG_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        CG_IDLE: begin
          cnt_d = '0;
          if (env) st_d = CG_HIGH;
        end
        CG_HIGH: begin
          if (hi_end) begin
            cnt_d = '0;
            st_d  = env ? CG_LOW : CG_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        CG_LOW: begin
          if (!env) begin
            cnt_d = '0;
            st_d  = CG_IDLE;
          end else if (lo_end) begin
            cnt_d = '0;
            st_d  = CG_HIGH;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_d = '0;
          st_d  = CG_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CG_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pulse_hi = (st_q == CG_HIGH);

  // R10: an unfinished high phase stays high even when the envelope closes
  p_no_trunc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (car_en && st_q == CG_HIGH && !hi_end && $stable(hi_lim)) |=> (st_q == CG_HIGH));
  // R10: a high phase is never entered with the envelope closed
  p_start_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != CG_HIGH && !env) |=> (st_q != CG_HIGH));
  // R2: each new phase starts its count from zero
  p_phase_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != $past(st_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod #(
  parameter int CW  = 9,
  parameter int TW  = 9,
  parameter int DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [9:0] wr_data,
  output logic       tmr_done,
  output logic       ir_drive
);
  import ir_carrier_pkg::*;

  logic [CW-1:0] hi_q, hi_d, lo_q, lo_d;
  logic          byp_q, byp_d;
  logic [TW-1:0] pre_q, pre_d;
  logic          route_q, route_d;
  logic          ctrl_wr, start, flag_clr;
  logic          running, tick, env, pulse_hi;

  assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
  assign start    = ctrl_wr && wr_data[CTRL_START];
  assign flag_clr = ctrl_wr && !wr_data[CTRL_KEEP];

  always_comb begin
    hi_d    = hi_q;
    byp_d   = byp_q;
    lo_d    = lo_q;
    pre_d   = pre_q;
    route_d = route_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_HIGH: begin
          hi_d  = wr_data[CW-1:0];
          byp_d = wr_data[9];
        end
        ADDR_LOW:  lo_d    = wr_data[CW-1:0];
        ADDR_PRE:  pre_d   = wr_data[TW-1:0];
        ADDR_CTRL: route_d = wr_data[CTRL_ROUTE];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      byp_q   <= 1'b0;
      lo_q    <= '0;
      pre_q   <= '0;
      route_q <= 1'b0;
    end else begin
      hi_q    <= hi_d;
      byp_q   <= byp_d;
      lo_q    <= lo_d;
      pre_q   <= pre_d;
      route_q <= route_d;
    end
  end

  ir_prescaler #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .en   (running),
    .tick (tick)
  );

  ir_down_timer #(.W(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .preload (pre_q),
    .tick    (tick),
    .flag_clr(flag_clr),
    .running (running),
    .done    (tmr_done)
  );

  assign env = running && route_q;

  ir_carrier_gen #(.W(CW)) u_car (
    .clk     (clk),
    .rst_n   (rst_n),
    .env     (env),
    .car_en  (!byp_q),
    .hi_lim  (hi_q),
    .lo_lim  (lo_q),
    .pulse_hi(pulse_hi)
  );

  assign ir_drive = byp_q ? env : pulse_hi;

  // R9: with routing off the output never drives
  p_route_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_q && !pulse_hi) |-> !ir_drive);
  // R6: the flag can only rise as the timer stops
  p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_done) |-> !running);
endmodule

// File: tb/sim_ir_carrier_mod.sv
module sim_ir_carrier_mod;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [9:0] wr_data = 10'd0;
  logic       tmr_done, ir_drive;

  int n_chk = 0;
  int n_fail = 0;
  int pulses, wmin, wmax, gmin, gmax, first_hi, last_hi, done_at;

  always #2 clk = ~clk;

  ir_carrier_mod u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tmr_done(tmr_done), .ir_drive(ir_drive)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // samples cycle k = 0..n-1 after the last write edge
  task automatic capture(input int n);
    int w = 0;
    int g = 0;
    logic prev = 1'b0;
    pulses = 0; wmin = 1 << 20; wmax = 0; gmin = 1 << 20; gmax = 0;
    first_hi = -1; last_hi = -1; done_at = -1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tmr_done && done_at < 0) done_at = k;
      if (ir_drive) begin
        if (!prev) begin
          pulses++;
          if (first_hi < 0) first_hi = k;
          if (pulses > 1) begin
            if (g < gmin) gmin = g;
            if (g > gmax) gmax = g;
          end
          w = 0;
        end
        w++;
        last_hi = k;
      end else begin
        if (prev) begin
          if (w < wmin) wmin = w;
          if (w > wmax) wmax = w;
          g = 0;
        end
        g++;
      end
      prev = ir_drive;
    end
  endtask

  function automatic int exp_pulses(input int h, input int l, input int n);
    return (64 * n - 1) / (h + l + 2) + 1;
  endfunction

  task automatic t_reset;
    check("R1 drive after reset", int'(ir_drive), 0);
    check("R1 done after reset", int'(tmr_done), 0);
    capture(100);
    check("R1 R5 no pulses without start", pulses, 0);
    check("R1 done stays low", done_at, -1);
  endtask

  task automatic t_bypass;
    wr(2'd0, 10'h200);
    wr(2'd2, 10'd3);
    wr(2'd3, 10'b010 | 10'b001);
    capture(200);
    check("R4 single envelope pulse", pulses, 1);
    check("R4 envelope width 64N", wmax, 192);
    check("R5 envelope opens next cycle", first_hi, 0);
    check("R6 done at 64N", done_at, 192);
  endtask

  task automatic t_carrier(input int h, input int l, input int n, input string tag);
    int ep = exp_pulses(h, l, n);
    int es = 1 + (ep - 1) * (h + l + 2);
    wr(2'd0, 10'(h));
    wr(2'd1, 10'(l));
    wr(2'd2, 10'(n));
    wr(2'd3, 10'b011);
    capture(64 * n + h + l + 20);
    check({tag, " R2 pulse count"}, pulses, ep);
    check({tag, " R2 min high width"}, wmin, h + 1);
    check({tag, " R2 max high width"}, wmax, h + 1);
    check({tag, " R2 low gap"}, gmin, l + 1);
    check({tag, " R2 low gap max"}, gmax, l + 1);
    check({tag, " R10 first high one cycle late"}, first_hi, 1);
    check({tag, " R10 last pulse complete"}, last_hi, es + h);
    check({tag, " R6 done time"}, done_at, 64 * n);
  endtask

  task automatic t_low_bit9;
    wr(2'd0, 10'd0);
    wr(2'd1, 10'h202);
    wr(2'd2, 10'd1);
    wr(2'd3, 10'b011);
    capture(90);
    check("R3 low bit9 ignored gap", gmax, 3);
    check("R3 pulse count", pulses, exp_pulses(0, 2, 1));
    check("R2 zero high count one cycle", wmax, 1);
  endtask

  task automatic t_route_off;
    wr(2'd0, 10'd2);
    wr(2'd1, 10'd5);
    wr(2'd2, 10'd1);
    wr(2'd3, 10'b001);
    capture(90);
    check("R9 no drive when unrouted", pulses, 0);
    check("R9 done still set", done_at, 64);
  endtask

  task automatic t_flag;
    wr(2'd3, 10'b110);
    capture(80);
    check("R8 keep bit holds flag", int'(tmr_done), 1);
    check("R5 control write without start idle", pulses, 0);
    wr(2'd3, 10'b010);
    capture(2);
    check("R8 clear write drops flag", int'(tmr_done), 0);
  endtask

  task automatic t_restart;
    wr(2'd0, 10'h200);
    wr(2'd2, 10'd5);
    wr(2'd3, 10'b011);
    capture(100);
    check("R7 still running before restart", done_at, -1);
    wr(2'd2, 10'd1);
    wr(2'd3, 10'b011);
    capture(100);
    check("R7 output continuous from restart", first_hi, 0);
    check("R7 new envelope width", wmax, 64);
    check("R7 flag timed from restart", done_at, 64);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_carrier(2, 5, 2, "third duty");
    t_carrier(3, 3, 1, "half duty");
    t_carrier(4, 1, 1, "short low");
    t_low_bit9();
    t_route_off();
    t_flag();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule